// File: doc/BRIEF.md
# Arithmetic Unit with Status Flags

This block computes the sum, difference or bitwise combination of two 32-bit operands in a single combinational pass. Along with the result it produces six status flags: carry, overflow, sign, zero, auxiliary carry and parity. A compare operation produces the flags of a subtraction but marks its result as not to be written back. The result, the write-back qualifier and the flags all come straight from the current operands and operation code.

A six-bit flags register sits beside the datapath. When the update enable is high, the register loads the current flags on the rising clock edge. A separate mask-and-value write path lets control logic force any chosen flag bits to 0 or 1 in the same edge. In the bits it selects, the mask write takes priority over an arithmetic update.

Flag vector layout, used on `flags_now`, `flags_q`, `fwr_mask` and `fwr_val`: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Operation codes: 000 ADD, 001 SUB, 010 AND, 011 OR, 100 XOR, 101 CMP; 110 and 111 are reserved.

Top module: `flag_alu`

## Requirements
- R1: ADD (000) gives `result` = a + b modulo 2^32, and carry (bit 0) is 1 exactly when the unsigned sum exceeds 2^32 - 1.
- R2: SUB (001) gives `result` = a - b modulo 2^32, and carry (bit 0) is 1 exactly when a < b as unsigned numbers (a borrow).
- R3: For ADD, SUB and CMP, overflow (bit 5) is 1 exactly when the true signed result does not fit in 32-bit two's complement.
- R4: Sign (bit 4) equals result bit 31. Zero (bit 3) is 1 exactly when all 32 result bits are 0.
- R5: For ADD, auxiliary carry (bit 2) is 1 when a carry passes from bit 3 into bit 4. For SUB and CMP it is 1 when a borrow passes from bit 4 into bit 3.
- R6: Parity (bit 1) is 1 when result bits 7..0 hold an even number of ones; the higher result bits have no effect on it.
- R7: AND (010), OR (011) and XOR (100) give the bitwise result and force carry, overflow and auxiliary carry to 0.
- R8: CMP (101) gives the same `result` and flags as SUB but holds `wb_valid` at 0. ADD, SUB and the logic operations raise `wb_valid`. Reserved codes (110, 111) give `result` = 0, all-zero `flags_now` and `wb_valid` = 0, and never load the flags register.
- R9: On a rising edge with `flag_upd` high and a non-reserved code, `flags_q` loads `flags_now`. Otherwise, with `fwr_mask` zero, it holds its value.
- R10: On a rising edge, each `flags_q` bit whose `fwr_mask` bit is 1 takes the matching `fwr_val` bit, overriding any update. Bits whose mask bit is 0 behave as R9 describes.
- R11: While `rst_n` is low, `flags_q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | First operand (minuend for SUB and CMP) |
| op_b | input | 32 | Second operand (subtrahend for SUB and CMP) |
| op_code | input | 3 | Operation select |
| flag_upd | input | 1 | Load `flags_now` into the register on this edge |
| fwr_mask | input | 6 | Flag bits to force directly |
| fwr_val | input | 6 | Values for the forced flag bits |
| result | output | 32 | Combinational result |
| wb_valid | output | 1 | Result is meant to be written back |
| flags_now | output | 6 | Combinational flags of the current operation |
| flags_q | output | 6 | Registered flags |

## Verification
The register assertions assume that `op_code`, `flag_upd` and the mask inputs are stable around each rising edge. They also assume that a cycle with a nonzero `fwr_mask` is judged by the forcing rule alone. The stimulus changes every input on the falling edge, so each value is settled before the next rising edge. It keeps `fwr_mask` at zero except in the cycles that exercise forcing and priority. The combinational checks put in operands that reach the corner cases at the edges of the ranges: signed and unsigned overflow, a carry or borrow across the nibble boundary, a result of zero, and a low byte whose parity differs from the parity of the whole result.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 32,
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_code,
  input  logic             flag_upd,
  input  logic [NFLAG-1:0] fwr_mask,
  input  logic [NFLAG-1:0] fwr_val,
  output logic [WIDTH-1:0] result,
  output logic             wb_valid,
  output logic [NFLAG-1:0] flags_now,
  output logic [NFLAG-1:0] flags_q
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                         OP_OR  = 3'd3, OP_XOR = 3'd4, OP_CMP = 3'd5;

  logic [WIDTH:0]     sum_w, dif_w;
  logic               is_add, is_sub, is_logic, op_ok;
  logic               cf, of, af;
  logic [WIDTH-1:0]   nib_x;
  logic [NFLAG-1:0]   flags_nx;

  assign sum_w    = {1'b0, op_a} + {1'b0, op_b};
  assign dif_w    = {1'b0, op_a} - {1'b0, op_b};
  assign is_add   = (op_code == OP_ADD);
  assign is_sub   = (op_code == OP_SUB) || (op_code == OP_CMP);
  assign is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
  assign op_ok    = is_add || is_sub || is_logic;

  always_comb begin
    unique case (op_code)
      OP_ADD:         result = sum_w[MSB:0];
      OP_SUB, OP_CMP: result = dif_w[MSB:0];
      OP_AND:         result = op_a & op_b;
      OP_OR:          result = op_a | op_b;
      OP_XOR:         result = op_a ^ op_b;
      default:        result = '0;
    endcase
  end

  assign nib_x = op_a ^ op_b ^ result;
  assign cf = is_add ? sum_w[WIDTH] : (is_sub ? dif_w[WIDTH] : 1'b0);
  assign af = (is_add || is_sub) && nib_x[4];
  assign of = is_add ? ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])) :
              is_sub ? ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])) : 1'b0;

  assign flags_now = op_ok ? {of, result[MSB], ~|result, af, ~^result[7:0], cf} : '0;
  assign wb_valid  = is_add || (op_code == OP_SUB) || is_logic;

  assign flags_nx = (((flag_upd && op_ok) ? flags_now : flags_q) & ~fwr_mask) | (fwr_val & fwr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nx;
  end

  p_cmp_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP) |-> !wb_valid);
  p_resv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code[2:1] == 2'b11) |-> (!wb_valid && flags_now == '0 && result == '0));
  p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (flags_now[0] == 1'b0 && flags_now[5] == 1'b0 && flags_now[2] == 1'b0));
  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_ok |-> (flags_now[4] == result[MSB]));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && op_ok && fwr_mask == '0) |=> (flags_q == $past(flags_now)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!flag_upd || !op_ok) && fwr_mask == '0) |=> $stable(flags_q));
  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwr_mask != '0) |=> ((flags_q & $past(fwr_mask)) == ($past(fwr_val) & $past(fwr_mask))));
endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {op[105:103], a[102:71], b[70:39], res[38:7], flags[6:1], wb[0]}
  localparam logic [105:0] VEC [NV] = '{
    {3'd0, 32'h00000001, 32'h00000001, 32'h00000002, 6'b000000, 1'b1},
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 6'b001111, 1'b1},
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 6'b110110, 1'b1},
    {3'd0, 32'h0000000F, 32'h00000001, 32'h00000010, 6'b000100, 1'b1},
    {3'd1, 32'h00000005, 32'h00000003, 32'h00000002, 6'b000000, 1'b1},
    {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 6'b010101, 1'b1},
    {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 6'b100110, 1'b1},
    {3'd1, 32'h00000010, 32'h00000001, 32'h0000000F, 6'b000110, 1'b1},
    {3'd5, 32'h00001234, 32'h00001234, 32'h00000000, 6'b001010, 1'b0},
    {3'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 6'b010010, 1'b1},
    {3'd3, 32'h00000003, 32'h0000000C, 32'h0000000F, 6'b000010, 1'b1},
    {3'd4, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 6'b001010, 1'b1},
    {3'd4, 32'h80000001, 32'h00000000, 32'h80000001, 6'b010000, 1'b1},
    {3'd6, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 6'b000000, 1'b0}
  };
  localparam string VTAG [NV] = '{"R1", "R1 R6", "R3 R4", "R5", "R2", "R2 R5",
    "R3 R6", "R5", "R8", "R7", "R7", "R7 R4", "R6", "R8"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0]  op_code = '0;
  logic        flag_upd = 1'b0;
  logic [5:0]  fwr_mask = '0, fwr_val = '0;
  logic [31:0] result;
  logic        wb_valid;
  logic [5:0]  flags_now, flags_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu i_flag_alu (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_code(op_code), .flag_upd(flag_upd), .fwr_mask(fwr_mask), .fwr_val(fwr_val),
    .result(result), .wb_valid(wb_valid), .flags_now(flags_now), .flags_q(flags_q));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic upd, input logic [5:0] m, input logic [5:0] v);
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; flag_upd = upd; fwr_mask = m; fwr_val = v;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flags_q == 6'b0, "R11 reset", {26'b0, flags_q}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][105:103], VEC[i][102:71], VEC[i][70:39], 1'b0, 6'b0, 6'b0);
      #1;
      check(result == VEC[i][38:7], {VTAG[i], " result"}, result, VEC[i][38:7]);
      check(flags_now == VEC[i][6:1], {VTAG[i], " flags"}, {26'b0, flags_now}, {26'b0, VEC[i][6:1]});
      check(wb_valid == VEC[i][0], {VTAG[i], " wb_valid"}, {31'b0, wb_valid}, {31'b0, VEC[i][0]});
    end

    drive(3'd0, 32'hFFFFFFFF, 32'h1, 1'b1, 6'b0, 6'b0);
    @(negedge clk);
    check(flags_q == 6'b001111, "R9 load", {26'b0, flags_q}, 32'h0F);

    op_code = 3'd1; op_a = 32'h3; op_b = 32'h5; flag_upd = 1'b0;
    @(negedge clk);
    check(flags_q == 6'b001111, "R9 hold", {26'b0, flags_q}, 32'h0F);

    op_code = 3'd7; flag_upd = 1'b1;
    @(negedge clk);
    check(flags_q == 6'b001111, "R8 reserved no load", {26'b0, flags_q}, 32'h0F);

    flag_upd = 1'b0; fwr_mask = 6'b100001; fwr_val = 6'b100000;
    @(negedge clk);
    check(flags_q == 6'b101110, "R10 force", {26'b0, flags_q}, 32'h2E);

    op_code = 3'd1; op_a = 32'h3; op_b = 32'h5; flag_upd = 1'b1;
    fwr_mask = 6'b000001; fwr_val = 6'b000000;
    @(negedge clk);
    check(flags_q == 6'b010100, "R10 priority", {26'b0, flags_q}, 32'h14);

    fwr_mask = 6'b0; flag_upd = 1'b0;
    rst_n = 1'b0;
    #1;
    check(flags_q == 6'b0, "R11 async reset", {26'b0, flags_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    finish_run();
  end
endmodule